// File: doc/BRIEF.md
# Selectable-Order Digital Delta-Sigma Offset Generator

This block turns a static fractional word into a stream of small signed integer offsets. A fractional-N divider adds these offsets to its integer modulus. Over many steps the offsets average to the fraction. Their quantization error is pushed toward high frequencies, and the shaping gets steeper as the order rises. The block advances once per enabled rising clock edge. In its intended use that clock is the divider's own output.

The core is a chain of three first-order accumulators. Each accumulator feeds its residue to the next one. A differencing network recombines the carries, so that only the first stage's carry adds to the mean. The order (1, 2 or 3) is chosen at run time and captured while reset is held. The offset alphabet widens with the order: two, four or eight levels. A multi-modulus divider consumes the result.

Top module: `mash_dsm`

## Requirements
- R1: With order 1 captured (order code 1, or code 0, which also selects order 1), every valid offset is 0 or 1.
- R2: With order 2 captured (order code 2), every valid offset lies in the range -1 to 2.
- R3: With order 3 captured (order code 3), every valid offset lies in the range -3 to 4.
- R4: The fraction word F is unsigned and stands for F/65536. After N enabled steps from reset, the sum S of the offsets satisfies |S·65536 − F·N| < 3·65536, for every order.
- R5: While reset is high, and afterwards until the first edge with enable high, the offset reads 0 and the valid strobe is low.
- R6: The valid strobe is high for exactly the cycle after each rising edge sampled with enable high. After an edge with enable low, the strobe is low and the offset keeps its previous value.
- R7: The order select is sampled only while reset is high. A change to it outside reset has no effect until the next reset.
- R8: With order 1 and F = 0x4000, the offsets from reset repeat the pattern 0, 0, 0, 1.
- R9: With order 2 or 3 and F = 0x5555, the offset takes at least one value outside {0, 1} within 2000 steps.
- R10: The offset is a 4-bit two's-complement value. The order code is 2 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock (the divided output clock) |
| rst | input | 1 | Synchronous active-high reset; captures the order select |
| en | input | 1 | Advance the modulator on this edge |
| frac | input | 16 | Unsigned fraction word, value frac/65536 |
| order_sel | input | 2 | Modulator order code: 1, 2, 3 (0 acts as 1) |
| offset | output | 4 | Signed offset to add to the integer modulus |
| offset_vld | output | 1 | One-cycle strobe marking a fresh offset |

## Verification
The range properties assume that the fraction word holds still between resets. They also assume that the captured order is always 1, 2 or 3; the block ensures this by mapping code 0 to 1. The bench changes the fraction and the order only while reset is high, with one exception. It deliberately moves the order select outside reset, to show that the change is ignored. Enable is driven between clock edges, so each stored offset comes from exactly one enabled step.

// File: rtl/mash_pkg.sv
package mash_pkg;
   localparam int unsigned FRAC_W   = 16;
   localparam int unsigned OFS_W    = 4;
   localparam int unsigned N_STAGES = 3;

   typedef enum logic [1:0] {
      ORD_DEF = 2'd0,
      ORD_1   = 2'd1,
      ORD_2   = 2'd2,
      ORD_3   = 2'd3
   } order_e;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] sum_next,
   output logic         carry
);
   logic [W-1:0] acc;
   logic [W:0]   wide_sum;

   always_comb begin
      wide_sum = {1'b0, acc} + {1'b0, din};
      sum_next = wide_sum[W-1:0];
      carry    = wide_sum[W];
   end

   always_ff @(posedge clk) begin
      if (rst)     acc <= '0;
      else if (en) acc <= sum_next;
   end
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel
   import mash_pkg::*;
#(
   parameter int unsigned OW = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  order_e               ord,
   input  logic                 c1,
   input  logic                 c2,
   input  logic                 c3,
   output logic signed [OW-1:0] y
);
   logic c2_d, c3_d, c3_dd;
   logic signed [OW-1:0] t1, t2, t3;

   function automatic logic signed [OW-1:0] widen(input logic b);
      return {{(OW-1){1'b0}}, b};
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         c2_d  <= 1'b0;
         c3_d  <= 1'b0;
         c3_dd <= 1'b0;
      end else if (en) begin
         c2_d  <= c2;
         c3_d  <= c3;
         c3_dd <= c3_d;
      end
   end

   always_comb begin
      t1 = widen(c1);
      t2 = (ord == ORD_2 || ord == ORD_3) ? (widen(c2) - widen(c2_d)) : '0;
      t3 = (ord == ORD_3) ? (widen(c3) - (widen(c3_d) <<< 1) + widen(c3_dd)) : '0;
      y  = t1 + t2 + t3;
   end
endmodule

// File: rtl/mash_dsm.sv
module mash_dsm
   import mash_pkg::*;
#(
   parameter int unsigned FW = FRAC_W,
   parameter int unsigned OW = OFS_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic [FW-1:0]        frac,
   input  logic [1:0]           order_sel,
   output logic signed [OW-1:0] offset,
   output logic                 offset_vld
);
   localparam int unsigned NS = N_STAGES;

   if (OW < 4) begin : g_bad_ow
      $error("mash_dsm: OW must be at least 4 to hold offsets -3..4");
   end
   if (FW < 2) begin : g_bad_fw
      $error("mash_dsm: FW must be at least 2");
   end

   order_e ord_q;
   logic [FW-1:0] stage_in  [NS];
   logic [FW-1:0] stage_sum [NS];
   logic [NS-1:0] carries;
   logic signed [OW-1:0] y_comb;

   always_ff @(posedge clk) begin
      if (rst) ord_q <= (order_sel == 2'd0) ? ORD_1 : order_e'(order_sel);
   end

   for (genvar k = 0; k < NS; k++) begin : g_stage
      if (k == 0) begin : g_first
         assign stage_in[k] = frac;
      end else begin : g_next
         assign stage_in[k] = stage_sum[k-1];
      end
      mash_acc_stage #(.W(FW)) u_acc (
         .clk      (clk),
         .rst      (rst),
         .en       (en),
         .din      (stage_in[k]),
         .sum_next (stage_sum[k]),
         .carry    (carries[k])
      );
   end

   mash_cancel #(.OW(OW)) u_cancel (
      .clk (clk),
      .rst (rst),
      .en  (en),
      .ord (ord_q),
      .c1  (carries[0]),
      .c2  (carries[1]),
      .c3  (carries[2]),
      .y   (y_comb)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         offset     <= '0;
         offset_vld <= 1'b0;
      end else begin
         offset_vld <= en;
         if (en) offset <= y_comb;
      end
   end
endmodule

// File: rtl/mash_dsm_chk.sv
module mash_dsm_chk #(
   parameter int unsigned OW = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 en,
   input logic [1:0]           order_sel,
   input logic [1:0]           ord_q,
   input logic signed [OW-1:0] offset,
   input logic                 offset_vld
);
   assert_range_o1_R1: assert property (@(posedge clk) disable iff (rst)
      (offset_vld && ord_q == 2'd1) |-> (offset == 0 || offset == 1));

   assert_range_o2_R2: assert property (@(posedge clk) disable iff (rst)
      (offset_vld && ord_q == 2'd2) |-> (offset >= -1 && offset <= 2));

   assert_range_o3_R3: assert property (@(posedge clk) disable iff (rst)
      (offset_vld && ord_q == 2'd3) |-> (offset >= -3 && offset <= 4));

   assert_reset_clear_R5: assert property (@(posedge clk)
      rst |=> (offset == 0 && !offset_vld));

   assert_vld_follows_en_R6: assert property (@(posedge clk) disable iff (rst)
      en |=> offset_vld);

   assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
      !en |=> (!offset_vld && $stable(offset)));

   assert_order_frozen_R7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> $stable(ord_q));

   assert_order_legal_R1: assert property (@(posedge clk)
      rst |=> (ord_q != 2'd0));
endmodule

bind mash_dsm mash_dsm_chk #(.OW(OW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .en         (en),
   .order_sel  (order_sel),
   .ord_q      (ord_q),
   .offset     (offset),
   .offset_vld (offset_vld)
);

// File: tb/mash_dsm_bench.sv
module mash_dsm_bench;
   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              en  = 1'b0;
   logic [15:0]       frac = '0;
   logic [1:0]        order_sel = 2'd1;
   logic signed [3:0] offset;
   logic              offset_vld;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   mash_dsm u_mash_dsm (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .frac       (frac),
      .order_sel  (order_sel),
      .offset     (offset),
      .offset_vld (offset_vld)
   );

   // vector fields: order code, fraction, step count
   localparam int NV = 8;
   localparam logic [33:0] VEC [NV] = '{
      {2'd1, 16'h4000, 16'd800},
      {2'd1, 16'h5555, 16'd2000},
      {2'd0, 16'hFFFF, 16'd1500},
      {2'd2, 16'h5555, 16'd2000},
      {2'd2, 16'h0001, 16'd1000},
      {2'd3, 16'h5555, 16'd2000},
      {2'd3, 16'hC3A7, 16'd2000},
      {2'd3, 16'h0000, 16'd300}
   };

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] ord, input logic [15:0] f);
      @(negedge clk);
      rst = 1'b1; en = 1'b0; order_sel = ord; frac = f;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R5: reset state, then idle until the first enabled edge
      do_reset(2'd3, 16'h5555);
      check(offset == 0 && !offset_vld, "R5 reset state", offset, 0);
      repeat (3) @(negedge clk);
      check(offset == 0 && !offset_vld, "R5 idle after reset", offset, 0);

      // table walk: ranges (R1 R2 R3), mean (R4), wider alphabet (R9)
      for (int v = 0; v < NV; v++) begin
         logic [1:0]  ord;
         logic [15:0] f;
         int          n, eff, bad_rng, outside;
         longint      sum, diff;
         ord = VEC[v][33:32]; f = VEC[v][31:16]; n = int'(VEC[v][15:0]);
         eff = (ord == 2'd0) ? 1 : int'(ord);
         sum = 0; bad_rng = 0; outside = 0;
         do_reset(ord, f);
         en = 1'b1;
         for (int i = 0; i < n; i++) begin
            int y;
            @(negedge clk);
            y = int'(offset);
            sum += y;
            if (y < 0 || y > 1) outside++;
            if (!offset_vld) bad_rng++;
            if (eff == 1 && (y < 0 || y > 1)) bad_rng++;
            if (eff == 2 && (y < -1 || y > 2)) bad_rng++;
            if (eff == 3 && (y < -3 || y > 4)) bad_rng++;
            // R8: exact first-order pattern for a quarter fraction
            if (eff == 1 && f == 16'h4000)
               check(y == (((i % 4) == 3) ? 1 : 0), "R8 pattern 0,0,0,1", y, ((i % 4) == 3) ? 1 : 0);
         end
         en = 1'b0;
         if (eff == 1) check(bad_rng == 0, "R1 order-1 range/valid", bad_rng, 0);
         if (eff == 2) check(bad_rng == 0, "R2 order-2 range/valid", bad_rng, 0);
         if (eff == 3) check(bad_rng == 0, "R3 order-3 range/valid", bad_rng, 0);
         diff = sum * 65536 - longint'(f) * longint'(n);
         if (diff < 0) diff = -diff;
         check(diff < 3 * 65536, "R4 mean equals fraction", sum, (longint'(f) * n) / 65536);
         if (eff >= 2 && f == 16'h5555)
            check(outside > 0, "R9 extra output levels used", outside, 1);
      end

      // R6: single enabled step, then idle: strobe drops and offset holds
      do_reset(2'd1, 16'hFFFF);
      en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      check(offset_vld == 1'b1, "R6 strobe after enabled edge", offset_vld, 1);
      check(offset == 0, "R6 first offset for FFFF", offset, 0);
      en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      check(offset == 1, "R6 second offset for FFFF", offset, 1);
      @(negedge clk);
      check(offset_vld == 1'b0, "R6 strobe low when idle", offset_vld, 0);
      check(offset == 1, "R6 offset held when idle", offset, 1);
      repeat (2) @(negedge clk);
      check(offset == 1 && !offset_vld, "R6 offset still held", offset, 1);

      // R7: order change outside reset is ignored (stays order 1, R10 code 3 applied late)
      begin
         int bad;
         bad = 0;
         do_reset(2'd1, 16'h5555);
         order_sel = 2'd3;
         en = 1'b1;
         for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (offset < 0 || offset > 1) bad++;
         end
         en = 1'b0;
         check(bad == 0, "R7 late order change ignored", bad, 0);
      end

      // R7/R10: the same code takes effect after a reset
      begin
         int outside;
         outside = 0;
         do_reset(2'd3, 16'h5555);
         en = 1'b1;
         for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (offset < 0 || offset > 1) outside++;
         end
         en = 1'b0;
         check(outside > 0, "R10 order code 3 active after reset", outside, 1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule